// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects up to 32 level-sensitive interrupt request lines and turns them into two processor-facing outputs: a vectored normal interrupt (`irq_o`) and a fast interrupt (`fiq_o`). Software configures it over a small word-addressed register bus. Through that bus it can enable or disable each source, steer each source to the normal or the fast class, and give each source its own handler address.

When an enabled normal-class source requests service, the controller finds the winning source, raises `irq_o` and latches that source's handler address into a current-handler register. The lowest-numbered source has the highest priority. The interrupt routine reads the current-handler register to fetch the address, and that read also marks the source as in service. From then on only a strictly higher-priority source can raise `irq_o` again, which gives nested interrupts. Writing the current-handler register retires the highest-priority source that is in service.

The fast-class output is not vectored. It is the registered OR of all enabled fast-class requests.

Register word offsets:

| Offset | Access | Contents |
|---|---|---|
| 0 | read-only | normal-class status |
| 1 | read-only | fast-class status |
| 2 | write-1-to-set, read | enable |
| 3 | write-1-to-clear, reads 0 | enable clear |
| 4 | read/write | class select |
| 5 | read/write | current handler |
| 32+n | read/write | handler address of source n |

Bit n of each per-source register belongs to source n.

Top module: `vic_core`

## Requirements
- R1: After reset, `irq_o` and `fiq_o` are 0, and reads return 0 for the enable register (offset 2), the class register (offset 4), the current-handler register (offset 5) and every handler register.
- R2: Writing offset 2 sets each enable bit whose data bit is 1 and leaves the others unchanged, so a write of 0 has no effect. A read of offset 2 returns the enable bits.
- R3: Writing offset 3 clears each enable bit whose data bit is 1 and leaves the others unchanged. A read of offset 3 returns 0.
- R4: Class bit n = 0 puts source n in the normal class and 1 puts it in the fast class. Offset 0 reads request & enable & ~class, and offset 1 reads request & enable & class.
- R5: `fiq_o` is 1 one clock after any enabled fast-class request is high, and 0 one clock after none is high. Fast-class sources never raise `irq_o`.
- R6: With no source in service, `irq_o` rises one clock after an enabled normal-class request appears. At the same edge, offset 5 takes the handler address of the lowest-numbered such source.
- R7: Offset 32+n holds a full 32-bit handler address for source n and reads back what was written.
- R8: A read of offset 5 while `irq_o` is 1 marks the latched source as in service. `irq_o` then falls after that edge unless a lower-numbered source is pending.
- R9: While sources are in service, only a pending source numbered below the lowest in-service source raises `irq_o`, and offset 5 then takes its handler address.
- R10: A write to offset 5 retires the lowest-numbered in-service source. At that edge offset 5 takes the written data if no source is eligible, or else the handler address of the new winner, and `irq_o` follows.
- R11: A read of offset 5 while `irq_o` is 0 changes no in-service state.
- R12: A request on a disabled source affects neither output nor either status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src_i | input | NUM_SRC | Level-sensitive request lines, bit n = source n |
| bus_sel_i | input | 1 | Bus access strobe for this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Register word offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current offset (combinational) |
| irq_o | output | 1 | Vectored normal-class interrupt request |
| fiq_o | output | 1 | Fast-class interrupt request |

## Verification
The in-service mask is the state most likely to go wrong, and it stays hidden until the next priority decision. A wrongly set bit shows up one clock later as an `irq_o` that stays low for a pending source. A bit that fails to set shows up as an `irq_o` that does not fall after the acknowledging read. A wrong retire order shows up only once a second, nested source has been acknowledged, so the bench steps through an acknowledge, nest, retire, retire sequence and checks `irq_o` and offset 5 at every step. A stale winner index shows up as the wrong handler address on the very next read of offset 5.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 6;

    // register word offsets
    localparam int OFS_IRQ_STAT = 0;
    localparam int OFS_FIQ_STAT = 1;
    localparam int OFS_EN_SET   = 2;
    localparam int OFS_EN_CLR   = 3;
    localparam int OFS_CLASS    = 4;
    localparam int OFS_CUR      = 5;
    localparam int OFS_VEC_BASE = 32;

    typedef struct packed {
        logic              sel;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    typedef enum logic [1:0] {
        SRC_IDLE     = 2'd0,
        SRC_PEND     = 2'd1,
        SRC_SERV     = 2'd2,
        SRC_SERV_PND = 2'd3
    } src_state_e;

    function automatic logic addr_is(input logic [ADDR_W-1:0] a, input int ofs);
        return a == ADDR_W'(ofs);
    endfunction

    function automatic src_state_e src_state(input logic pend, input logic serv);
        return src_state_e'({serv, pend});
    endfunction

endpackage

// File: rtl/vic_regs.sv
module vic_regs import vic_pkg::*; #(
    parameter int NUM_SRC = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  bus_req_t                       bus,
    input  logic [NUM_SRC-1:0]             irq_src,
    input  logic [DATA_W-1:0]              cur_addr,
    output logic [NUM_SRC-1:0]             en_o,
    output logic [NUM_SRC-1:0]             sel_o,
    output logic [NUM_SRC-1:0][DATA_W-1:0] vec_o,
    output logic                           rd_cur_o,
    output logic                           wr_cur_o,
    output logic [DATA_W-1:0]              rdata_o
);

    logic                           wr_en;
    logic                           rd_en;
    logic [NUM_SRC-1:0]             en_q;
    logic [NUM_SRC-1:0]             sel_q;
    logic [NUM_SRC-1:0][DATA_W-1:0] vec_q;

    assign wr_en    = bus.sel &  bus.wr;
    assign rd_en    = bus.sel & ~bus.wr;
    assign rd_cur_o = rd_en & addr_is(bus.addr, OFS_CUR);
    assign wr_cur_o = wr_en & addr_is(bus.addr, OFS_CUR);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            sel_q <= '0;
        end else if (wr_en) begin
            if (addr_is(bus.addr, OFS_EN_SET))
                en_q <= en_q | bus.wdata[NUM_SRC-1:0];
            else if (addr_is(bus.addr, OFS_EN_CLR))
                en_q <= en_q & ~bus.wdata[NUM_SRC-1:0];
            else if (addr_is(bus.addr, OFS_CLASS))
                sel_q <= bus.wdata[NUM_SRC-1:0];
        end
    end

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_vec
        always_ff @(posedge clk) begin
            if (rst)
                vec_q[n] <= '0;
            else if (wr_en && addr_is(bus.addr, OFS_VEC_BASE + n))
                vec_q[n] <= bus.wdata;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_is(bus.addr, OFS_IRQ_STAT))
            rdata_o = DATA_W'(irq_src & en_q & ~sel_q);
        else if (addr_is(bus.addr, OFS_FIQ_STAT))
            rdata_o = DATA_W'(irq_src & en_q & sel_q);
        else if (addr_is(bus.addr, OFS_EN_SET))
            rdata_o = DATA_W'(en_q);
        else if (addr_is(bus.addr, OFS_CLASS))
            rdata_o = DATA_W'(sel_q);
        else if (addr_is(bus.addr, OFS_CUR))
            rdata_o = cur_addr;
        for (int n = 0; n < NUM_SRC; n++)
            if (addr_is(bus.addr, OFS_VEC_BASE + n))
                rdata_o = vec_q[n];
    end

    assign en_o  = en_q;
    assign sel_o = sel_q;
    assign vec_o = vec_q;

endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter import vic_pkg::*; #(
    parameter int NUM_SRC = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_SRC-1:0]             irq_src,
    input  logic [NUM_SRC-1:0]             en,
    input  logic [NUM_SRC-1:0]             sel,
    input  logic [NUM_SRC-1:0][DATA_W-1:0] vec,
    input  logic                           rd_cur,
    input  logic                           wr_cur,
    input  logic [DATA_W-1:0]              wdata,
    output logic                           irq_o,
    output logic                           fiq_o,
    output logic [DATA_W-1:0]              cur_addr_o,
    output logic [NUM_SRC-1:0]             act_o
);

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [NUM_SRC-1:0] act_q, act_nxt, pend, below, elig, win_oh, top_act;
    logic [IDX_W-1:0]   win_idx, win_q;
    logic               irq_q, fiq_q;
    logic [DATA_W-1:0]  cur_q;

    assign pend    = irq_src & en & ~sel;
    assign top_act = act_q & (~act_q + NUM_SRC'(1));

    // in-service mask after this cycle's acknowledge / retire
    always_comb begin
        act_nxt = act_q;
        if (rd_cur && irq_q)
            act_nxt[win_q] = 1'b1;
        if (wr_cur)
            act_nxt = act_nxt & ~top_act;
    end

    // only sources numbered below the lowest in-service one may compete
    always_comb begin
        if (act_nxt == '0)
            below = '1;
        else
            below = (act_nxt & (~act_nxt + NUM_SRC'(1))) - NUM_SRC'(1);
        elig   = pend & below;
        win_oh = elig & (~elig + NUM_SRC'(1));
        win_idx = '0;
        for (int n = 0; n < NUM_SRC; n++)
            if (win_oh[n])
                win_idx = IDX_W'(n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            irq_q <= 1'b0;
            fiq_q <= 1'b0;
            cur_q <= '0;
            win_q <= '0;
        end else begin
            act_q <= act_nxt;
            irq_q <= |elig;
            fiq_q <= |(irq_src & en & sel);
            if (|elig) begin
                cur_q <= vec[win_idx];
                win_q <= win_idx;
            end else if (wr_cur) begin
                cur_q <= wdata;
            end
        end
    end

    assign irq_o      = irq_q;
    assign fiq_o      = fiq_q;
    assign cur_addr_o = cur_q;
    assign act_o      = act_q;

endmodule

// File: rtl/vic_core.sv
module vic_core import vic_pkg::*; #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_src_i,
    input  logic               bus_sel_i,
    input  logic               bus_wr_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic               irq_o,
    output logic               fiq_o
);

    bus_req_t                       bus;
    logic [NUM_SRC-1:0]             en_w, sel_w, act_w;
    logic [NUM_SRC-1:0][DATA_W-1:0] vec_w;
    logic                           rd_cur_w, wr_cur_w;
    logic [DATA_W-1:0]              cur_w;

    assign bus = '{sel: bus_sel_i, wr: bus_wr_i, addr: bus_addr_i, wdata: bus_wdata_i};

    vic_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus      (bus),
        .irq_src  (irq_src_i),
        .cur_addr (cur_w),
        .en_o     (en_w),
        .sel_o    (sel_w),
        .vec_o    (vec_w),
        .rd_cur_o (rd_cur_w),
        .wr_cur_o (wr_cur_w),
        .rdata_o  (bus_rdata_o)
    );

    vic_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .clk        (clk),
        .rst        (rst),
        .irq_src    (irq_src_i),
        .en         (en_w),
        .sel        (sel_w),
        .vec        (vec_w),
        .rd_cur     (rd_cur_w),
        .wr_cur     (wr_cur_w),
        .wdata      (bus_wdata_i),
        .irq_o      (irq_o),
        .fiq_o      (fiq_o),
        .cur_addr_o (cur_w),
        .act_o      (act_w)
    );

endmodule

// File: rtl/vic_core_chk.sv
module vic_core_chk #(
    parameter int NUM_SRC = 32
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] irq_src_i,
    input logic               irq_o,
    input logic               fiq_o,
    input logic [NUM_SRC-1:0] en_w,
    input logic [NUM_SRC-1:0] sel_w,
    input logic [NUM_SRC-1:0] act_w,
    input logic               rd_cur_w,
    input logic               wr_cur_w
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!irq_o && !fiq_o && act_w == '0));

    assert_fiq_needs_req_R5: assert property (@(posedge clk) disable iff (rst)
        !(|(irq_src_i & en_w & sel_w)) |=> !fiq_o);

    assert_irq_needs_req_R6: assert property (@(posedge clk) disable iff (rst)
        !(|(irq_src_i & en_w & ~sel_w)) |=> !irq_o);

    assert_ack_marks_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_cur_w && irq_o) |=> (|(act_w & ~$past(act_w))));

    assert_retire_one_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_cur_w && act_w != '0) |=> ($countones(act_w) == $countones($past(act_w)) - 1));

    assert_quiet_read_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_cur_w && !irq_o) |=> (act_w == $past(act_w)));

endmodule

bind vic_core vic_core_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_src_i (irq_src_i),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o),
    .en_w      (en_w),
    .sel_w     (sel_w),
    .act_w     (act_w),
    .rd_cur_w  (rd_cur_w),
    .wr_cur_w  (wr_cur_w)
);

// File: tb/vic_core_test.sv
module vic_core_test;
    import vic_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [31:0]       src = '0;
    logic              bsel = 1'b0, bwr = 1'b0;
    logic [ADDR_W-1:0] baddr = '0;
    logic [31:0]       bwdata = '0;
    logic [31:0]       brdata;
    logic              irq, fiq;
    int                n_cmp = 0, n_bad = 0;
    logic [31:0]       rd;

    always #4 clk = ~clk;  // 125 MHz

    vic_core #(.NUM_SRC(32)) uut (
        .clk(clk), .rst(rst), .irq_src_i(src),
        .bus_sel_i(bsel), .bus_wr_i(bwr), .bus_addr_i(baddr),
        .bus_wdata_i(bwdata), .bus_rdata_o(brdata),
        .irq_o(irq), .fiq_o(fiq)
    );

    typedef struct packed {
        logic [31:0] en, sel, req;
        logic        x_irq, x_fiq;
        logic [31:0] x_ist, x_fst, x_cur;
    } row_t;

    // handler address of source n is 0x100 + 4n
    localparam row_t TBL [8] = '{
        '{32'h0000_0000, 32'h0, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0},
        '{32'h0000_0010, 32'h0, 32'h0000_0010, 1'b1, 1'b0, 32'h10, 32'h0, 32'h110},
        '{32'h0000_0030, 32'h0, 32'h0000_0030, 1'b1, 1'b0, 32'h30, 32'h0, 32'h110},
        '{32'h0000_0030, 32'h10, 32'h0000_0030, 1'b1, 1'b1, 32'h20, 32'h10, 32'h114},
        '{32'h8000_0001, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1, 32'h0, 32'h8000_0000, 32'h0},
        '{32'h8000_0001, 32'h0, 32'h8000_0001, 1'b1, 1'b0, 32'h8000_0001, 32'h0, 32'h100},
        '{32'hFFFF_0000, 32'h0, 32'h0000_FFFF, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0},
        '{32'hC000_0000, 32'h0, 32'hFFFF_FFFF, 1'b1, 1'b0, 32'hC000_0000, 32'h0, 32'h178}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input int ofs, input logic [31:0] d);
        @(negedge clk);
        bsel = 1'b1; bwr = 1'b1; baddr = ADDR_W'(ofs); bwdata = d;
        @(negedge clk);
        bsel = 1'b0; bwr = 1'b0;
    endtask

    task automatic bus_read(input int ofs, output logic [31:0] d);
        @(negedge clk);
        bsel = 1'b1; bwr = 1'b0; baddr = ADDR_W'(ofs);
        #1 d = brdata;
        @(negedge clk);
        bsel = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 irq_o", {31'b0, irq}, 32'h0);
        check("R1 fiq_o", {31'b0, fiq}, 32'h0);
        bus_read(OFS_EN_SET, rd);   check("R1 enable", rd, 32'h0);
        bus_read(OFS_CLASS, rd);    check("R1 class", rd, 32'h0);
        bus_read(OFS_CUR, rd);      check("R1 current", rd, 32'h0);
        bus_read(OFS_VEC_BASE + 7, rd); check("R1 handler 7", rd, 32'h0);

        // R2 / R3: set and clear enables
        bus_write(OFS_EN_SET, 32'h5);
        bus_write(OFS_EN_SET, 32'h0);
        bus_read(OFS_EN_SET, rd);   check("R2 write 0 no effect", rd, 32'h5);
        bus_write(OFS_EN_SET, 32'h8);
        bus_read(OFS_EN_SET, rd);   check("R2 set accumulates", rd, 32'hD);
        bus_write(OFS_EN_CLR, 32'h0);
        bus_read(OFS_EN_SET, rd);   check("R3 write 0 no effect", rd, 32'hD);
        bus_write(OFS_EN_CLR, 32'h4);
        bus_read(OFS_EN_SET, rd);   check("R3 clear one bit", rd, 32'h9);
        bus_read(OFS_EN_CLR, rd);   check("R3 clear reads 0", rd, 32'h0);

        // R7: handler registers
        for (int n = 0; n < 32; n++)
            bus_write(OFS_VEC_BASE + n, 32'h100 + 32'(4 * n));
        bus_read(OFS_VEC_BASE, rd);      check("R7 handler 0", rd, 32'h100);
        bus_read(OFS_VEC_BASE + 31, rd); check("R7 handler 31", rd, 32'h17C);

        // table walk: R4 R5 R6 R12
        for (int i = 0; i < 8; i++) begin
            bus_write(OFS_EN_CLR, 32'hFFFF_FFFF);
            bus_write(OFS_EN_SET, TBL[i].en);
            bus_write(OFS_CLASS, TBL[i].sel);
            src = TBL[i].req;
            @(negedge clk);
            check($sformatf("R6/R12 row %0d irq_o", i), {31'b0, irq}, {31'b0, TBL[i].x_irq});
            check($sformatf("R5 row %0d fiq_o", i), {31'b0, fiq}, {31'b0, TBL[i].x_fiq});
            bus_read(OFS_IRQ_STAT, rd); check($sformatf("R4 row %0d irq status", i), rd, TBL[i].x_ist);
            bus_read(OFS_FIQ_STAT, rd); check($sformatf("R4 row %0d fiq status", i), rd, TBL[i].x_fst);
            if (TBL[i].x_irq) begin
                bus_read(OFS_CUR, rd); check($sformatf("R6 row %0d current", i), rd, TBL[i].x_cur);
                bus_write(OFS_CUR, 32'h0);
            end
        end

        // nesting: R8 R9 R10
        bus_write(OFS_EN_CLR, 32'hFFFF_FFFF);
        bus_write(OFS_CLASS, 32'h0);
        src = '0;
        bus_write(OFS_EN_SET, 32'h224);
        src = 32'h20;
        @(negedge clk);
        check("R6 irq source 5", {31'b0, irq}, 32'h1);
        bus_read(OFS_CUR, rd);      check("R6 current source 5", rd, 32'h114);
        check("R8 irq falls after ack", {31'b0, irq}, 32'h0);
        src = 32'h220;
        @(negedge clk);
        check("R9 lower priority blocked", {31'b0, irq}, 32'h0);
        src = 32'h224;
        @(negedge clk);
        check("R9 higher priority raises", {31'b0, irq}, 32'h1);
        bus_read(OFS_CUR, rd);      check("R9 current source 2", rd, 32'h108);
        check("R8 irq falls after nested ack", {31'b0, irq}, 32'h0);
        src = 32'h220;
        bus_write(OFS_CUR, 32'h0);
        check("R10 no winner after first retire", {31'b0, irq}, 32'h0);
        bus_read(OFS_CUR, rd);      check("R10 current takes written data", rd, 32'h0);
        bus_write(OFS_CUR, 32'h0);
        check("R10 re-raise after second retire", {31'b0, irq}, 32'h1);
        bus_read(OFS_VEC_BASE + 40 - 40 + 0, rd);
        bus_read(OFS_IRQ_STAT, rd); check("R10 status after retire", rd, 32'h220);
        bus_read(OFS_CUR, rd);      check("R10 current source 5", rd, 32'h114);
        bus_write(OFS_CUR, 32'h0);
        bus_write(OFS_CUR, 32'h0);

        // R11: read while irq low leaves in-service state alone
        bus_write(OFS_EN_CLR, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R11 irq low before read", {31'b0, irq}, 32'h0);
        bus_read(OFS_CUR, rd);
        bus_write(OFS_EN_SET, 32'h20);
        @(negedge clk);
        check("R11 source 5 still raises irq", {31'b0, irq}, 32'h1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule